// File: doc/BRIEF.md
# Microcode Store Load Port

This block is the register-level port through which software loads a writeable microcode store. It has three registers on a small register bus. The first is a 16-bit load-address register, which holds a 13-bit word address, a 2-bit sub-word counter and one spare bit. The second is a 32-bit data port. The third is a 13-bit micro-breakpoint register. Each write to the data port sends a one-cycle store strobe to the microcode array outside this block. The strobe carries the word address, the sub-word counter and the data. The load address then advances by itself, so a loader can stream words through the data port without rewriting the address.

The sub-word counter counts data writes modulo four. The word address advances when the counter has just reached its top value. From a counter of zero, the word address therefore steps on the third write, and once in every four writes after that. Reads are combinational from the register select. The data port always reads back a fixed pattern and never the data that was written.

The strobe is sequenced by a two-state machine. It has two states: `ST_IDLE`, where no strobe is driven, and `ST_EMIT`, where the strobe is driven. The transition `fire` moves the machine to `ST_EMIT`, and is taken on any cycle that carries a data write. The transition `rest` returns it to `ST_IDLE` on a cycle without a data write. Back-to-back data writes keep the machine in `ST_EMIT`, so a burst of writes produces one strobe per cycle.

Top module: `ucode_load_port`

## Requirements
- R1: After reset, the address register and the breakpoint register read as zero, and the store strobe is low.
- R2: With select 0 (the address register), a write stores bits 15:0 of the write data. A read returns those 16 bits, and bits 31:16 read as zero.
- R3: With select 1 (the data port), a write adds one modulo 4 to the counter in address bits 14:13. It leaves address bit 15 unchanged.
- R4: If a data write leaves the counter equal to 3, the word address in bits 12:0 also adds one, wrapping from 0x1FFF to 0. Otherwise the word address is unchanged.
- R5: The store strobe is high for exactly the one cycle after each clock edge that samples a data write, and low at all other times. Back-to-back data writes give one strobe per write.
- R6: During a strobe, the strobe's word address and counter hold their values from before the increment, and the strobe data holds all 32 bits of the write data.
- R7: A read with select 1 returns 0x000000FF, whatever was written.
- R8: With select 2 (the breakpoint register), a write keeps bits 12:0 of the write data. A read returns them, with bits 31:13 zero.
- R9: Select 3 is not decoded. It reads as zero, and a write to it changes neither the address register nor the breakpoint register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data port, 2 breakpoint, 3 undecoded |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| ws_valid | output | 1 | Store strobe, one cycle per data write |
| ws_word | output | 13 | Word address carried by the strobe |
| ws_ctr | output | 2 | Sub-word counter carried by the strobe |
| ws_data | output | 32 | Data word carried by the strobe |

## Verification
Register writes take effect at the clock edge that samples them, and read data is combinational. A write is therefore visible on `rd_data` in the cycle after that edge. The strobe and its three fields come from registers loaded at the same edge, so they are due in that same following cycle. The bench drives its inputs just after each falling edge. Its reference model updates on the rising edge, and every output is compared with the model at the next falling edge, after all registers have settled. This keeps every comparison exactly one edge after the stimulus it depends on.

// File: rtl/ucl_pkg.sv
package ucl_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_BRK  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } strobe_state_t;

endpackage

// File: rtl/ucl_addr_reg.sv
module ucl_addr_reg #(
    parameter int WORD_W = 13,
    parameter int CTR_W  = 2,
    parameter int SPARE_W = 1,
    localparam int REG_W = WORD_W + CTR_W + SPARE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [REG_W-1:0] ld_val,
    input  logic             step_en,
    output logic [REG_W-1:0] addr_q
);
    localparam logic [CTR_W-1:0] CTR_TOP = '1;

    logic [WORD_W-1:0]  word_cur;
    logic [CTR_W-1:0]   ctr_cur;
    logic [SPARE_W-1:0] spare_cur;
    logic [CTR_W-1:0]   ctr_nxt;
    logic [WORD_W-1:0]  word_nxt;

    assign word_cur  = addr_q[WORD_W-1:0];
    assign ctr_cur   = addr_q[WORD_W +: CTR_W];
    assign spare_cur = addr_q[REG_W-1 -: SPARE_W];

    always_comb begin
        ctr_nxt  = ctr_cur + 1'b1;
        word_nxt = word_cur;
        if (ctr_nxt == CTR_TOP) begin
            word_nxt = word_cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_en) begin
            addr_q <= ld_val;
        end else if (step_en) begin
            addr_q <= {spare_cur, ctr_nxt, word_nxt};
        end
    end

endmodule

// File: rtl/ucl_strobe_fsm.sv
module ucl_strobe_fsm
    import ucl_pkg::*;
#(
    parameter int WORD_W = 13,
    parameter int CTR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [CTR_W-1:0]  cur_ctr,
    output logic              ws_valid,
    output logic [WORD_W-1:0] ws_word,
    output logic [CTR_W-1:0]  ws_ctr
);
    strobe_state_t state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [CTR_W-1:0]  ctr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire)  state_d = ST_EMIT;
            ST_EMIT: if (!fire) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            ctr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                word_q <= cur_word;
                ctr_q  <= cur_ctr;
            end
        end
    end

    always_comb begin
        ws_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ws_valid = 1'b0;
            ST_EMIT: ws_valid = 1'b1;
            default: ws_valid = 1'b0;
        endcase
        ws_word = word_q;
        ws_ctr  = ctr_q;
    end

endmodule

// File: rtl/ucl_read_mux.sv
module ucl_read_mux
    import ucl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int BRK_W  = 13,
    parameter logic [DATA_W-1:0] RD_CONST = 32'h0000_00FF
) (
    input  reg_sel_t          sel,
    input  logic [REG_W-1:0]  addr_q,
    input  logic [BRK_W-1:0]  brk_q,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_ADDR: rd_data = DATA_W'(addr_q);
            SEL_DATA: rd_data = RD_CONST;
            SEL_BRK:  rd_data = DATA_W'(brk_q);
            SEL_NONE: rd_data = '0;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ucode_load_port.sv
module ucode_load_port
    import ucl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = 13,
    parameter int CTR_W  = 2,
    parameter int BRK_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ws_valid,
    output logic [WORD_W-1:0] ws_word,
    output logic [CTR_W-1:0]  ws_ctr,
    output logic [DATA_W-1:0] ws_data
);
    localparam int REG_W = WORD_W + CTR_W + 1;

    reg_sel_t           sel;
    logic               wr_addr, wr_dport, wr_brk;
    logic [REG_W-1:0]   addr_q;
    logic [BRK_W-1:0]   brk_q;
    logic [DATA_W-1:0]  hold_q;

    assign sel      = reg_sel_t'(reg_sel);
    assign wr_addr  = wr_en && (sel == SEL_ADDR);
    assign wr_dport = wr_en && (sel == SEL_DATA);
    assign wr_brk   = wr_en && (sel == SEL_BRK);

    ucl_addr_reg #(.WORD_W(WORD_W), .CTR_W(CTR_W), .SPARE_W(1)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (wr_addr),
        .ld_val  (wr_data[REG_W-1:0]),
        .step_en (wr_dport),
        .addr_q  (addr_q)
    );

    ucl_strobe_fsm #(.WORD_W(WORD_W), .CTR_W(CTR_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (wr_dport),
        .cur_word (addr_q[WORD_W-1:0]),
        .cur_ctr  (addr_q[WORD_W +: CTR_W]),
        .ws_valid (ws_valid),
        .ws_word  (ws_word),
        .ws_ctr   (ws_ctr)
    );

    ucl_read_mux #(.DATA_W(DATA_W), .REG_W(REG_W), .BRK_W(BRK_W)) i_rmux (
        .sel     (sel),
        .addr_q  (addr_q),
        .brk_q   (brk_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q  <= '0;
            hold_q <= '0;
        end else begin
            if (wr_brk)   brk_q  <= wr_data[BRK_W-1:0];
            if (wr_dport) hold_q <= wr_data;
        end
    end

    assign ws_data = hold_q;

endmodule

// File: rtl/ucl_load_port_chk.sv
module ucl_load_port_chk #(
    parameter int DATA_W = 32,
    parameter int WORD_W = 13,
    parameter int CTR_W  = 2,
    parameter int BRK_W  = 13,
    localparam int REG_W = WORD_W + CTR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              ws_valid,
    input logic [WORD_W-1:0] ws_word,
    input logic [CTR_W-1:0]  ws_ctr,
    input logic [DATA_W-1:0] ws_data,
    input logic [REG_W-1:0]  addr_q
);
    logic dwr;
    assign dwr = wr_en && (reg_sel == 2'd1);

    // R5
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> ws_valid);
    // R5
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dwr |=> !ws_valid);
    // R6
    strobe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> (ws_data == $past(wr_data)));
    // R6
    strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> ({ws_ctr, ws_word} == $past(addr_q[WORD_W+CTR_W-1:0])));
    // R3
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> (addr_q[WORD_W +: CTR_W] == CTR_W'($past(addr_q[WORD_W +: CTR_W]) + 1'b1))
                && (addr_q[REG_W-1] == $past(addr_q[REG_W-1])));
    // R7
    data_read_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1) |-> (rd_data == 32'h0000_00FF));
    // R8
    brk_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2) |-> (rd_data[DATA_W-1:BRK_W] == '0));
    // R9
    undecoded_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (rd_data == '0));
    // R9
    undecoded_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3) |=> $stable(addr_q));

endmodule

bind ucode_load_port ucl_load_port_chk #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .CTR_W(CTR_W), .BRK_W(BRK_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .ws_valid (ws_valid),
    .ws_word  (ws_word),
    .ws_ctr   (ws_ctr),
    .ws_data  (ws_data),
    .addr_q   (addr_q)
);

// File: tb/test_ucode_load_port.sv
`timescale 1ns/100ps
module test_ucode_load_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ws_valid;
    logic [12:0] ws_word;
    logic [1:0]  ws_ctr;
    logic [31:0] ws_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ucode_load_port i_ucode_load_port (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ws_valid(ws_valid),
        .ws_word(ws_word), .ws_ctr(ws_ctr), .ws_data(ws_data)
    );

    // behavioural reference model
    int          m_addr = 0;
    int          m_brk = 0;
    bit          m_valid = 0;
    int          m_wword = 0;
    int          m_wctr = 0;
    logic [31:0] m_wdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_brk = 0; m_valid = 0;
        end else begin
            m_valid = 0;
            if (wr_en) begin
                case (reg_sel)
                    2'd0: m_addr = int'(wr_data & 32'hFFFF);
                    2'd1: begin
                        int c, w;
                        m_valid = 1;
                        m_wword = m_addr & 'h1FFF;
                        m_wctr  = (m_addr >> 13) & 3;
                        m_wdata = wr_data;
                        c = (m_wctr + 1) % 4;
                        w = m_wword;
                        if (c == 3) w = (w + 1) % 8192;
                        m_addr = (m_addr & 'h8000) | (c << 13) | w;
                    end
                    2'd2: m_brk = int'(wr_data & 32'h1FFF);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0: return 32'(m_addr);
            2'd1: return 32'h0000_00FF;
            2'd2: return 32'(m_brk);
            default: return 32'h0;
        endcase
    endfunction

    // compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            case (reg_sel)
                2'd0: chk("R2/R3/R4 addr read", rd_data, exp_rd(reg_sel));
                2'd1: chk("R7 data read", rd_data, exp_rd(reg_sel));
                2'd2: chk("R8 brk read", rd_data, exp_rd(reg_sel));
                default: chk("R9 undecoded read", rd_data, exp_rd(reg_sel));
            endcase
            chk("R5 strobe", 32'(ws_valid), 32'(m_valid));
            if (m_valid) begin
                chk("R6 strobe word", 32'(ws_word), 32'(m_wword));
                chk("R6 strobe ctr", 32'(ws_ctr), 32'(m_wctr));
                chk("R6 strobe data", ws_data, m_wdata);
            end
        end
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk); #0.5;
        reg_sel = s; wr_en = 1'b1; wr_data = d;
        @(negedge clk); #0.5;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(logic [1:0] s, logic [31:0] exp, string req);
        @(negedge clk); #0.5;
        reg_sel = s;
        @(negedge clk); #0.2;
        chk(req, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;
        // R1 reset state
        rd_expect(2'd0, 32'h0, "R1 addr after reset");
        rd_expect(2'd2, 32'h0, "R1 brk after reset");
        chk("R1 strobe after reset", 32'(ws_valid), 32'h0);
        // R2 address write
        wr(2'd0, 32'hFFFF_ABCD);
        rd_expect(2'd0, 32'h0000_ABCD, "R2 addr write");
        // R4 wrap, R3 spare bit kept
        wr(2'd0, 32'h0000_DFFF);
        wr(2'd1, 32'h1234_5678);
        rd_expect(2'd0, 32'h0000_E000, "R4 word wrap, R3 bit15 kept");
        wr(2'd1, 32'h0);
        rd_expect(2'd0, 32'h0000_8000, "R3 ctr wrap to 0");
        // R4 step on third write from 0
        wr(2'd0, 32'h0000_0010);
        wr(2'd1, 32'hA);
        wr(2'd1, 32'hB);
        rd_expect(2'd0, 32'h0000_4010, "R4 no step before ctr 3");
        wr(2'd1, 32'hC);
        rd_expect(2'd0, 32'h0000_6011, "R4 step at ctr 3");
        // R5 back-to-back burst
        @(negedge clk); #0.5;
        reg_sel = 2'd1; wr_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wr_data = 32'hC0DE_0000 + 32'(i);
            @(negedge clk); #0.5;
        end
        wr_en = 1'b0;
        // R7 data port read
        rd_expect(2'd1, 32'h0000_00FF, "R7 data read const");
        // R8 breakpoint
        wr(2'd2, 32'hFFFF_FFFF);
        rd_expect(2'd2, 32'h0000_1FFF, "R8 brk masks");
        // R9 undecoded write ignored
        wr(2'd0, 32'h0000_1234);
        wr(2'd3, 32'hFFFF_FFFF);
        rd_expect(2'd0, 32'h0000_1234, "R9 addr untouched");
        rd_expect(2'd2, 32'h0000_1FFF, "R9 brk untouched");
        rd_expect(2'd3, 32'h0, "R9 undecoded read");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #0.5;
            reg_sel = 2'($urandom_range(0, 3));
            wr_en   = ($urandom_range(0, 2) != 0);
            wr_data = $urandom;
        end
        @(negedge clk); #0.5;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule